// File: doc/BRIEF.md
# DSI Lane High-Speed Sequencer

This block decides, cycle by cycle in the byte clock domain, when the clock lane and the data lanes of a DSI host transmitter are driven in high-speed (HS) mode and when they fall back to low-power (LP). A packet source raises `tx_req` and hands over bytes on each cycle where `tx_ready` is high. It marks the last beat of a burst with `tx_last`. The sequencer wraps each burst in programmable delays: a lead-in with the clock running alone, an optional trail of end-of-transmission (EoT) packet strobes, a wait for the PHY to report stop state, a clock tail, and a minimum LP gap.

Two clock policies exist. In gated mode the clock lane returns to LP between bursts. In free-running mode it stays in HS, so a later burst reaches its data phase without the lead-in. A high-speed transmit watchdog limits how long the data lanes may stay in HS. When it expires, the burst is cut short and a sticky error flag is raised. Every setting is captured when a request is accepted in idle, so a setting changed during a burst has no effect on that burst.

Top module: `dsi_lane_seq`

## Requirements
- R1: When a burst starts with the clock lane in LP, `hs_clk_en` is high alone for max(`cfg_pre_cyc`,1) cycles before any bit of `hs_data_en` rises. No data lane is ever HS while `hs_clk_en` is low.
- R2: A lane-select value v turns on lanes 0 to min(v, MAX_LANES-1) of `hs_data_en`, and these lanes only, in every data cycle. With MAX_LANES=2: v=0 gives 2'b01, and v=1, 2 or 3 give 2'b11.
- R3: After the beat accepted with `tx_last`, `eot_strobe` is high for exactly (`cfg_eot_auto` ? 1 : 0) + `cfg_eot_extra` consecutive cycles. During those cycles the data lanes stay HS and `tx_ready` is low.
- R4: After the data lanes leave HS, `hs_clk_en` stays high for one cycle, plus one more cycle for every cycle in which `phy_stopstate` is still low.
- R5: With `cfg_clk_gated`=1, once stop state is accepted the clock lane stays HS for max(`cfg_post_cyc`,1) more cycles and then drops to LP.
- R6: With `cfg_clk_gated`=1, the clock lane stays LP for max(`cfg_gap_cyc`,1) cycles plus one idle cycle. If a request is already pending, it goes HS again after exactly that many low cycles.
- R7: With `cfg_clk_gated`=0, the clock lane stays HS after a burst. The next burst's data lanes go HS on the first edge that sees the request, with no lead-in.
- R8: With a non-zero `cfg_hs_limit` L, the data lanes stay HS for at most L cycles per burst. On the L-th cycle the burst ends without any remaining EoT strobes, and `hs_timeout_err` is set and stays set until `err_clear`. L=0 disables the limit.
- R9: All configuration inputs are sampled when a request is accepted in idle. Changing them during a burst does not alter that burst's lanes, EoT count, tail or clock policy.
- R10: During and right after reset all outputs are low.
- R11: `tx_ready` is high only in the data phase. The number of beats accepted equals the burst length given by `tx_last`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lane_sel | input | LSEL_W | Active lane count minus one |
| cfg_clk_gated | input | 1 | 1: clock lane LP between bursts; 0: free-running |
| cfg_pre_cyc | input | DLY_W | Clock lead-in before data HS (0 acts as 1) |
| cfg_post_cyc | input | DLY_W | Clock tail after stop state (0 acts as 1) |
| cfg_gap_cyc | input | DLY_W | Minimum clock LP time (0 acts as 1) |
| cfg_eot_auto | input | 1 | Emit one EoT packet at burst end |
| cfg_eot_extra | input | EOT_W | Additional EoT packets at burst end |
| cfg_hs_limit | input | TO_W | HS transmit watchdog limit, 0 disables |
| tx_req | input | 1 | Burst data pending |
| tx_last | input | 1 | Current beat ends the burst |
| tx_ready | output | 1 | Beat accepted this cycle when tx_req is high |
| phy_stopstate | input | 1 | PHY reports data lanes in stop state |
| err_clear | input | 1 | Clears the timeout error flag |
| hs_clk_en | output | 1 | Clock lane HS enable |
| hs_data_en | output | MAX_LANES | Per-lane data HS enable |
| eot_strobe | output | 1 | Emit one EoT short packet this cycle |
| hs_timeout_err | output | 1 | Sticky HS transmit timeout flag |

## Verification
The assertions assume that configuration inputs change only while the block is idle or in ways that the capture register hides. They also assume that `tx_last` is held meaningful only while a request is up. The bench changes settings between bursts, plus one deliberate mid-burst change that the capture stage must mask. The data source answers `tx_ready` from what it samples and follows a simple request/last discipline. `phy_stopstate` is held low only while data lanes are HS, or for a counted delay after they drop, so the stop-wait path is exercised with known lengths.

// File: rtl/dsi_lane_seq_pkg.sv
package dsi_lane_seq_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE      = 3'd0,
      SQ_LEAD      = 3'd1,
      SQ_DATA      = 3'd2,
      SQ_EOT       = 3'd3,
      SQ_STOPWAIT  = 3'd4,
      SQ_TAIL      = 3'd5,
      SQ_GAP       = 3'd6
   } seq_state_e;

   function automatic int unsigned wider(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dsi_seq_dcount.sv
module dsi_seq_dcount #(
   parameter int W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   output logic         expire
);
   logic [W-1:0] cnt_q;

   if (W < 2) begin : g_bad_w
      $error("dsi_seq_dcount: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (ld)             cnt_q <= ld_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - W'(1);
   end

   assign expire = (cnt_q == W'(1));

   // R1
   load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld |-> (ld_val != '0));

endmodule

// File: rtl/dsi_seq_hs_timer.sv
module dsi_seq_hs_timer #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic [W-1:0] limit,
   output logic         hit
);
   logic [W-1:0] cnt_q;

   if (W < 2) begin : g_bad_w
      $error("dsi_seq_hs_timer: W must be at least 2");
   end

   assign hit = run && (limit != '0) && (cnt_q == limit - W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (!run || hit)  cnt_q <= '0;
      else                   cnt_q <= cnt_q + W'(1);
   end

   // R8
   within_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && limit != '0) |-> (cnt_q < limit));

endmodule

// File: rtl/dsi_seq_lane_mask.sv
module dsi_seq_lane_mask #(
   parameter int LANES = 2,
   parameter int SEL_W = 2
) (
   input  logic             on,
   input  logic [SEL_W-1:0] sel,
   output logic [LANES-1:0] en
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      if (i == 0) begin : g_first
         assign en[i] = on;
      end else begin : g_rest
         assign en[i] = on && (32'(sel) >= 32'(i));
      end
   end
endmodule

// File: rtl/dsi_lane_seq.sv
module dsi_lane_seq
   import dsi_lane_seq_pkg::*;
#(
   parameter int MAX_LANES = 2,
   parameter int LSEL_W    = 2,
   parameter int DLY_W     = 8,
   parameter int EOT_W     = 8,
   parameter int TO_W      = 24
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [LSEL_W-1:0]    cfg_lane_sel,
   input  logic                 cfg_clk_gated,
   input  logic [DLY_W-1:0]     cfg_pre_cyc,
   input  logic [DLY_W-1:0]     cfg_post_cyc,
   input  logic [DLY_W-1:0]     cfg_gap_cyc,
   input  logic                 cfg_eot_auto,
   input  logic [EOT_W-1:0]     cfg_eot_extra,
   input  logic [TO_W-1:0]      cfg_hs_limit,
   input  logic                 tx_req,
   input  logic                 tx_last,
   output logic                 tx_ready,
   input  logic                 phy_stopstate,
   input  logic                 err_clear,
   output logic                 hs_clk_en,
   output logic [MAX_LANES-1:0] hs_data_en,
   output logic                 eot_strobe,
   output logic                 hs_timeout_err
);
   localparam int CW = int'(wider(DLY_W, EOT_W)) + 1;

   if (MAX_LANES < 1 || MAX_LANES > 4) begin : g_bad_lanes
      $error("dsi_lane_seq: MAX_LANES must be 1..4");
   end
   if ((1 << LSEL_W) < MAX_LANES) begin : g_bad_sel
      $error("dsi_lane_seq: LSEL_W too narrow for MAX_LANES");
   end
   if (DLY_W < 1 || EOT_W < 1 || TO_W < 2) begin : g_bad_width
      $error("dsi_lane_seq: field widths too small");
   end

   function automatic logic [CW-1:0] at_least_one(input logic [DLY_W-1:0] v);
      return (v == '0) ? CW'(1) : CW'(v);
   endfunction

   seq_state_e state_q, state_d;
   logic       keep_q, keep_d;
   logic       err_q;
   logic       capture, ld, err_set, expire, to_hit, data_on;
   logic [CW-1:0] ld_val, eot_total;

   logic [LSEL_W-1:0] lsel_q;
   logic              gated_q, auto_q;
   logic [DLY_W-1:0]  post_q, gap_q;
   logic [EOT_W-1:0]  extra_q;
   logic [TO_W-1:0]   limit_q;

   assign eot_total = CW'(extra_q) + CW'(auto_q);

   always_comb begin
      state_d = state_q;
      keep_d  = keep_q;
      capture = 1'b0;
      ld      = 1'b0;
      ld_val  = '0;
      err_set = 1'b0;
      unique case (state_q)
         SQ_IDLE: begin
            if (tx_req) begin
               capture = 1'b1;
               keep_d  = 1'b0;
               if (keep_q) begin
                  state_d = SQ_DATA;
               end else begin
                  state_d = SQ_LEAD;
                  ld      = 1'b1;
                  ld_val  = at_least_one(cfg_pre_cyc);
               end
            end
         end
         SQ_LEAD: begin
            if (expire) state_d = SQ_DATA;
         end
         SQ_DATA: begin
            if (to_hit) begin
               state_d = SQ_STOPWAIT;
               err_set = 1'b1;
            end else if (tx_req && tx_last) begin
               if (eot_total != '0) begin
                  state_d = SQ_EOT;
                  ld      = 1'b1;
                  ld_val  = eot_total;
               end else begin
                  state_d = SQ_STOPWAIT;
               end
            end
         end
         SQ_EOT: begin
            if (to_hit) begin
               state_d = SQ_STOPWAIT;
               err_set = 1'b1;
            end else if (expire) begin
               state_d = SQ_STOPWAIT;
            end
         end
         SQ_STOPWAIT: begin
            if (phy_stopstate) begin
               if (gated_q) begin
                  state_d = SQ_TAIL;
                  ld      = 1'b1;
                  ld_val  = at_least_one(post_q);
               end else begin
                  state_d = SQ_IDLE;
                  keep_d  = 1'b1;
               end
            end
         end
         SQ_TAIL: begin
            if (expire) begin
               state_d = SQ_GAP;
               ld      = 1'b1;
               ld_val  = at_least_one(gap_q);
            end
         end
         SQ_GAP: begin
            if (expire) state_d = SQ_IDLE;
         end
         default: state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         keep_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         keep_q  <= keep_d;
         if (err_set)        err_q <= 1'b1;
         else if (err_clear) err_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lsel_q  <= '0;
         gated_q <= 1'b0;
         auto_q  <= 1'b0;
         post_q  <= '0;
         gap_q   <= '0;
         extra_q <= '0;
         limit_q <= '0;
      end else if (capture) begin
         lsel_q  <= cfg_lane_sel;
         gated_q <= cfg_clk_gated;
         auto_q  <= cfg_eot_auto;
         post_q  <= cfg_post_cyc;
         gap_q   <= cfg_gap_cyc;
         extra_q <= cfg_eot_extra;
         limit_q <= cfg_hs_limit;
      end
   end

   dsi_seq_dcount #(.W(CW)) u_dly (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (ld),
      .ld_val (ld_val),
      .expire (expire)
   );

   assign data_on = (state_q == SQ_DATA) || (state_q == SQ_EOT);

   dsi_seq_hs_timer #(.W(TO_W)) u_hs_to (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (data_on),
      .limit (limit_q),
      .hit   (to_hit)
   );

   dsi_seq_lane_mask #(.LANES(MAX_LANES), .SEL_W(LSEL_W)) u_lanes (
      .on  (data_on),
      .sel (lsel_q),
      .en  (hs_data_en)
   );

   assign tx_ready       = (state_q == SQ_DATA);
   assign eot_strobe     = (state_q == SQ_EOT);
   assign hs_timeout_err = err_q;
   assign hs_clk_en      = ((state_q != SQ_IDLE) && (state_q != SQ_GAP)) ||
                           ((state_q == SQ_IDLE) && keep_q);

   // R1
   data_needs_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|hs_data_en) |-> hs_clk_en);

   // R1
   clk_before_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|hs_data_en) |-> $past(hs_clk_en));

   // R2
   ready_on_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> hs_data_en[0]);

   // R3
   eot_in_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eot_strobe |-> (hs_data_en[0] && !tx_ready));

   // R5
   clk_drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hs_clk_en) |-> (!(|hs_data_en) && $past(!(|hs_data_en))));

   // R6
   gap_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hs_clk_en) |=> !hs_clk_en);

   // R8
   sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_timeout_err && !err_clear) |=> hs_timeout_err);

endmodule

// File: tb/tb_dsi_lane_seq.sv
`timescale 1ns/1ps
module tb_dsi_lane_seq;
   localparam int LANES = 2;
   localparam int WIN   = 70;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_lane_sel = '0;
   logic        cfg_clk_gated = 1'b1;
   logic [7:0]  cfg_pre_cyc = 8'd1, cfg_post_cyc = 8'd1, cfg_gap_cyc = 8'd2;
   logic        cfg_eot_auto = 1'b0;
   logic [7:0]  cfg_eot_extra = '0;
   logic [23:0] cfg_hs_limit = '0;
   logic        tx_req = 1'b0, tx_last = 1'b0, phy_stopstate = 1'b1, err_clear = 1'b0;
   logic        tx_ready, hs_clk_en, eot_strobe, hs_timeout_err;
   logic [LANES-1:0] hs_data_en;

   always #10 clk = ~clk;

   dsi_lane_seq dut (
      .clk(clk), .rst_n(rst_n), .cfg_lane_sel(cfg_lane_sel), .cfg_clk_gated(cfg_clk_gated),
      .cfg_pre_cyc(cfg_pre_cyc), .cfg_post_cyc(cfg_post_cyc), .cfg_gap_cyc(cfg_gap_cyc),
      .cfg_eot_auto(cfg_eot_auto), .cfg_eot_extra(cfg_eot_extra), .cfg_hs_limit(cfg_hs_limit),
      .tx_req(tx_req), .tx_last(tx_last), .tx_ready(tx_ready), .phy_stopstate(phy_stopstate),
      .err_clear(err_clear), .hs_clk_en(hs_clk_en), .hs_data_en(hs_data_en),
      .eot_strobe(eot_strobe), .hs_timeout_err(hs_timeout_err)
   );

   int n_chk = 0, n_err = 0;
   bit warm = 1'b0;
   int m_pre, m_dat, m_eot, m_tail, m_low, m_mask;
   bit m_clk_end;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int clamp1(input int v);
      return (v == 0) ? 1 : v;
   endfunction

   function automatic int lane_mask(input int sel);
      int n = sel + 1;
      if (n > LANES) n = LANES;
      return (1 << n) - 1;
   endfunction

   task automatic burst(input int len, input int sd, input bit rearm, input bit scramble);
      int beats = 0, since = 0;
      bit seen = 0, off = 0, gone = 0, back = 0, scr = 0;
      m_pre = 0; m_dat = 0; m_eot = 0; m_tail = 0; m_low = 0; m_mask = 0;
      @(negedge clk);
      tx_req = 1'b1;
      tx_last = (len == 1);
      for (int c = 0; c < WIN; c++) begin
         @(negedge clk);
         if (beats >= len + (rearm ? 1 : 0)) tx_req = 1'b0;
         if (!off) begin
            if (|hs_data_en) begin
               seen = 1;
               m_mask = m_mask | int'(hs_data_en);
               if (tx_ready) m_dat++;
               if (eot_strobe) m_eot++;
               if (scramble && !scr) begin
                  scr = 1;
                  cfg_post_cyc = 8'd9; cfg_eot_extra = 8'd5; cfg_lane_sel = 2'd0;
                  cfg_clk_gated = 1'b0; cfg_hs_limit = 24'd2;
               end
            end else if (seen) begin
               off = 1;
            end else if (hs_clk_en) begin
               m_pre++;
            end
         end
         if (off) begin
            if (!gone) begin
               if (hs_clk_en) m_tail++;
               else gone = 1;
            end
            if (gone && !back) begin
               if (hs_clk_en) back = 1;
               else m_low++;
            end
            if (!rearm) tx_req = 1'b0;
            phy_stopstate = (since >= sd);
            since++;
         end else begin
            phy_stopstate = !(|hs_data_en);
         end
         tx_last = (beats >= len - 1);
         if (tx_ready && tx_req) beats++;
         m_clk_end = hs_clk_en;
      end
      tx_req = 1'b0;
      phy_stopstate = 1'b1;
   endtask

   task automatic set_cfg(input bit gated, input int pre, input int post, input int gap,
                          input bit aut, input int extra, input int lsel, input int lim);
      cfg_clk_gated = gated; cfg_pre_cyc = 8'(pre); cfg_post_cyc = 8'(post);
      cfg_gap_cyc = 8'(gap); cfg_eot_auto = aut; cfg_eot_extra = 8'(extra);
      cfg_lane_sel = 2'(lsel); cfg_hs_limit = 24'(lim);
   endtask

   initial begin
      int k = 0;
      repeat (3) @(negedge clk);
      chk("R10 clk in reset", int'(hs_clk_en), 0);
      chk("R10 data in reset", int'(hs_data_en), 0);
      chk("R10 ready in reset", int'(tx_ready), 0);
      chk("R10 eot in reset", int'(eot_strobe), 0);
      chk("R10 err in reset", int'(hs_timeout_err), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R10 clk after reset", int'(hs_clk_en), 0);
      chk("R10 data after reset", int'(hs_data_en), 0);

      // sweep: R1 R2 R3 R5 R7 R11
      for (int mode = 0; mode < 2; mode++)
         for (int pre = 0; pre < 4; pre += 2)
            for (int post = 0; post < 6; post += 3)
               for (int aut = 0; aut < 2; aut++)
                  for (int ex = 0; ex < 3; ex += 2)
                     for (int len = 1; len < 4; len += 2) begin
                        int exp_pre;
                        set_cfg(mode[0], pre, post, 2, aut[0], ex, k % 4, 0);
                        exp_pre = warm ? 0 : clamp1(pre);
                        burst(len, 0, 0, 0);
                        if (warm) chk("R7 no lead-in when clock kept", m_pre, exp_pre);
                        else      chk("R1 lead-in cycles", m_pre, exp_pre);
                        chk("R11 beats", m_dat, len);
                        chk("R3 eot strobes", m_eot, aut + ex);
                        chk("R2 lane mask", m_mask, lane_mask(k % 4));
                        if (mode == 1) begin
                           chk("R5 clock tail", m_tail, 1 + clamp1(post));
                           chk("R5 clock off at end", int'(m_clk_end), 0);
                           warm = 0;
                        end else begin
                           chk("R7 clock kept HS", int'(m_clk_end), 1);
                           warm = 1;
                        end
                        k++;
                     end

      // R6 gap with pending request
      for (int gap = 0; gap < 5; gap++) begin
         set_cfg(1, 1, 1, gap, 0, 0, 0, 0);
         burst(2, 0, 1, 0);
         chk("R6 low clock cycles", m_low, clamp1(gap) + 1);
      end
      warm = 0;

      // R4 stop-state wait
      set_cfg(1, 1, 2, 1, 0, 0, 1, 0);
      burst(2, 3, 0, 0);
      chk("R4 tail with stop delay", m_tail, 4 + 2);
      chk("R4 clock off at end", int'(m_clk_end), 0);

      // R8 timeout
      set_cfg(1, 1, 1, 1, 1, 0, 1, 3);
      burst(6, 0, 0, 0);
      chk("R8 data cycles capped", m_dat, 3);
      chk("R8 no eot after timeout", m_eot, 0);
      chk("R8 error set", int'(hs_timeout_err), 1);
      set_cfg(1, 1, 1, 1, 0, 0, 1, 0);
      burst(20, 0, 0, 0);
      chk("R8 limit zero disables", m_dat, 20);
      chk("R8 error sticky", int'(hs_timeout_err), 1);
      @(negedge clk); err_clear = 1'b1;
      @(negedge clk); err_clear = 1'b0;
      chk("R8 error cleared", int'(hs_timeout_err), 0);

      // R9 mid-burst config change
      set_cfg(1, 2, 3, 1, 1, 1, 1, 0);
      burst(3, 0, 0, 1);
      chk("R9 beats", m_dat, 3);
      chk("R9 eot count", m_eot, 2);
      chk("R9 lane mask", m_mask, 3);
      chk("R9 tail", m_tail, 4);
      chk("R9 clock policy", int'(m_clk_end), 0);
      chk("R9 no timeout", int'(hs_timeout_err), 0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog (all requirements): actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule